// File: doc/BRIEF.md
# Deflection-Aware Input Arbiter

This block arbitrates the inputs of a five-port mesh router that runs without input buffers. Every cycle each of the five inputs may present one packet, together with the output port the route logic picked for it, the number of times the packet has already been deflected, and the number of hops it has travelled. The arbiter works out which output ports are wanted by more than one packet, ranks the competing packets, and hands each requested port to the single best-ranked packet that asked for it.

Ranking is lexicographic: more past deflections wins; on equal deflections, more hops wins; on a full tie, a tie-break code taken from a free-running LFSR decides, so that no input is favoured for good. Losing packets are flagged as failed and leave with no port, to be steered elsewhere by a later deflection stage. Winners leave with their port and a hop count bumped by one. The set of output ports that nobody won is reported as the idle set, which the deflection stage consumes.

Decisions are combinational within the cycle; only the LFSR holds state and it advances on every clock.

Top module: `dpa_arbiter`

## Requirements
- R1: Every input with `in_valid` high has exactly one of `grant` and `fail` high; an input with `in_valid` low has both low.
- R2: A valid request for port code 0 to 4 (code 0 is the local port, codes 1 to 4 the four neighbour links) that no other valid input shares is always granted.
- R3: `contend[o]` is high exactly when two or more valid inputs request port code o; requests from inputs with `in_valid` low are not counted.
- R4: Each output port is granted to at most one input, and among the contenders for a port the winner has the largest deflection count.
- R5: Among contenders with equal, largest deflection count, the winner has the largest hop count.
- R6: When contenders tie on both counts exactly one of them is granted, and the choice follows a free-running LFSR: held constant for 40 cycles, a two-way tie is won at least once by each side.
- R7: `out_port[i]` equals the requested port code when input i is granted, and the code 7 (no port) otherwise.
- R8: `out_hops[i]` equals the input hop count plus one when input i is granted, saturating at 7; otherwise it equals the input hop count unchanged.
- R9: `idle_set[o]` is high exactly when no input is granted port code o; a request for a code of 5 or above is never granted and marks no port busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the LFSR seed |
| in_valid | input | 5 | Packet present on each input |
| in_port | input | 5x3 | Requested output port code per input |
| in_defl | input | 5x3 | Deflection count per input |
| in_hops | input | 5x3 | Hop count per input |
| grant | output | 5 | Input won its requested port |
| fail | output | 5 | Input lost arbitration |
| out_port | output | 5x3 | Assigned port per input, 7 when none |
| out_hops | output | 5x3 | Updated hop count per input |
| idle_set | output | 5 | Output ports left unused this cycle |
| contend | output | 5 | Output ports requested by two or more inputs |

## Verification
The bench sets up conflicts in which the hop count and the deflection count disagree, so a design that compared the fields in the wrong order, or summed them, hands the port to the packet with more hops instead of more deflections. It holds a full tie for many cycles and counts each side's wins, which catches a tie-break frozen to the input index (one side never wins) or a key that is not unique (both or neither granted). It also drives a hop count of 7, an out-of-range port code and an invalid input sitting on a contested port, where a design would wrap the count to 0, mark a phantom port busy, or let a dead input steal or falsely flag a port.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int NPORT  = 5;
  localparam int PORT_W = 3;
  localparam int CNT_W  = 3;
  localparam int TB_W   = 3;
  localparam int KEY_W  = 2 * CNT_W + TB_W;
  localparam logic [PORT_W-1:0] PORT_NONE = '1;

  // Lexicographic rank: deflections, then hops, then tie-break code.
  function automatic logic [KEY_W-1:0] rank_key(input logic [CNT_W-1:0] defl,
                                                input logic [CNT_W-1:0] hops,
                                                input logic [TB_W-1:0]  tb);
    return {defl, hops, tb};
  endfunction

  // Hop count after a successful forward, held at its ceiling.
  function automatic logic [CNT_W-1:0] hop_bump(input logic [CNT_W-1:0] h);
    return (h == '1) ? h : h + 1'b1;
  endfunction
endpackage

// File: rtl/dpa_lfsr.sv
module dpa_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= SEED;
    else if (state[0]) state <= (state >> 1) ^ TAPS;
    else               state <= state >> 1;
  end
endmodule

// File: rtl/dpa_contend.sv
module dpa_contend
  import dpa_pkg::*;
(
  input  logic [NPORT-1:0]             valid,
  input  logic [NPORT-1:0][PORT_W-1:0] port,
  output logic [NPORT-1:0][NPORT-1:0]  req,     // [output][input]
  output logic [NPORT-1:0]             contend
);
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++)
        req[o][i] = valid[i] && (port[i] == PORT_W'(o));
      contend[o] = ($countones(req[o]) >= 2);
    end
  end
endmodule

// File: rtl/dpa_pick.sv
module dpa_pick
  import dpa_pkg::*;
(
  input  logic [NPORT-1:0]            req,
  input  logic [NPORT-1:0][KEY_W-1:0] key,
  output logic [NPORT-1:0]            win
);
  logic [KEY_W-1:0] best;
  logic             found;
  always_comb begin
    best  = '0;
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (req[i] && (!found || key[i] > best)) begin
        best   = key[i];
        found  = 1'b1;
        win    = '0;
        win[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
  import dpa_pkg::*;
#(
  parameter int            LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             in_valid,
  input  logic [NPORT-1:0][PORT_W-1:0] in_port,
  input  logic [NPORT-1:0][CNT_W-1:0]  in_defl,
  input  logic [NPORT-1:0][CNT_W-1:0]  in_hops,
  output logic [NPORT-1:0]             grant,
  output logic [NPORT-1:0]             fail,
  output logic [NPORT-1:0][PORT_W-1:0] out_port,
  output logic [NPORT-1:0][CNT_W-1:0]  out_hops,
  output logic [NPORT-1:0]             idle_set,
  output logic [NPORT-1:0]             contend
);
  logic [LFSR_W-1:0]            lfsr_q;
  logic [NPORT-1:0][NPORT-1:0]  req;     // [output][input]
  logic [NPORT-1:0][NPORT-1:0]  win_oh;  // [output][input]
  logic [NPORT-1:0][KEY_W-1:0]  key;

  dpa_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(lfsr_q)
  );

  dpa_contend u_cont (
    .valid(in_valid), .port(in_port), .req(req), .contend(contend)
  );

  // XOR with a shared random value keeps tie-break codes distinct per input.
  for (genvar i = 0; i < NPORT; i++) begin : g_key
    assign key[i] = rank_key(in_defl[i], in_hops[i],
                             TB_W'(i) ^ lfsr_q[TB_W-1:0]);
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_pick
    dpa_pick u_pick (.req(req[o]), .key(key), .win(win_oh[o]));
  end

  always_comb begin
    idle_set = '1;
    for (int i = 0; i < NPORT; i++) begin
      grant[i] = 1'b0;
      for (int o = 0; o < NPORT; o++)
        grant[i] = grant[i] | win_oh[o][i];
      fail[i]     = in_valid[i] & ~grant[i];
      out_port[i] = grant[i] ? in_port[i] : PORT_NONE;
      out_hops[i] = grant[i] ? hop_bump(in_hops[i]) : in_hops[i];
    end
    for (int o = 0; o < NPORT; o++)
      idle_set[o] = ~(|win_oh[o]);
  end
endmodule

// File: rtl/dpa_arb_chk.sv
module dpa_arb_chk
  import dpa_pkg::*;
#(
  parameter int LFSR_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NPORT-1:0]             in_valid,
  input logic [NPORT-1:0][PORT_W-1:0] in_port,
  input logic [NPORT-1:0][CNT_W-1:0]  in_defl,
  input logic [NPORT-1:0][CNT_W-1:0]  in_hops,
  input logic [NPORT-1:0]             grant,
  input logic [NPORT-1:0]             fail,
  input logic [NPORT-1:0][PORT_W-1:0] out_port,
  input logic [NPORT-1:0][CNT_W-1:0]  out_hops,
  input logic [NPORT-1:0]             idle_set,
  input logic [NPORT-1:0]             contend,
  input logic [NPORT-1:0][NPORT-1:0]  win_oh,
  input logic [LFSR_W-1:0]            lfsr_q
);
  function automatic logic [NPORT-1:0] askers(input int o);
    for (int i = 0; i < NPORT; i++)
      askers[i] = in_valid[i] && (in_port[i] == PORT_W'(o));
  endfunction

  function automatic logic port_taken(input int o);
    port_taken = 1'b0;
    for (int i = 0; i < NPORT; i++)
      if (grant[i] && out_port[i] == PORT_W'(o)) port_taken = 1'b1;
  endfunction

  a_r1_grant_fail_split: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & fail) == '0) && ((grant | fail) == in_valid));

  a_r6_lfsr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr_q != '0) |=> (lfsr_q != $past(lfsr_q)));

  for (genvar o = 0; o < NPORT; o++) begin : g_port
    a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_oh[o]));
    a_r3_contend_match: assert property (@(posedge clk) disable iff (!rst_n)
      contend[o] == ($countones(askers(o)) >= 2));
    a_r9_idle_match: assert property (@(posedge clk) disable iff (!rst_n)
      idle_set[o] == !port_taken(o));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    a_r2_lone_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[i] && in_port[i] < PORT_W'(NPORT)
       && $countones(askers(int'(in_port[i]))) == 1) |-> grant[i]);
    a_r7_port_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_port[i] == (grant[i] ? in_port[i] : PORT_NONE));
    a_r8_hop_update: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> out_hops[i] == ((in_hops[i] == '1) ? in_hops[i]
                                                      : in_hops[i] + 1'b1));
    for (genvar j = 0; j < NPORT; j++) begin : g_pair
      if (i != j) begin : g_ne
        // R4 deflection count first, R5 hop count second
        a_r5_rank_order: assert property (@(posedge clk) disable iff (!rst_n)
          (grant[i] && fail[j] && in_port[j] == in_port[i]) |->
          (in_defl[i] > in_defl[j] ||
           (in_defl[i] == in_defl[j] && in_hops[i] >= in_hops[j])));
      end
    end
  end
endmodule

bind dpa_arbiter dpa_arb_chk #(.LFSR_W(LFSR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
  .in_defl(in_defl), .in_hops(in_hops), .grant(grant), .fail(fail),
  .out_port(out_port), .out_hops(out_hops), .idle_set(idle_set),
  .contend(contend), .win_oh(win_oh), .lfsr_q(lfsr_q)
);

// File: tb/dpa_arbiter_test.sv
module dpa_arbiter_test;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [4:0]       in_valid = '0;
  logic [4:0][2:0]  in_port = '0;
  logic [4:0][2:0]  in_defl = '0;
  logic [4:0][2:0]  in_hops = '0;
  logic [4:0]       grant, fail, idle_set, contend;
  logic [4:0][2:0]  out_port, out_hops;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dpa_arbiter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
    .in_defl(in_defl), .in_hops(in_hops), .grant(grant), .fail(fail),
    .out_port(out_port), .out_hops(out_hops), .idle_set(idle_set),
    .contend(contend)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = '0; in_port = '0; in_defl = '0; in_hops = '0;
  endtask

  task automatic put(input int i, input int p, input int d, input int h);
    in_valid[i] = 1'b1;
    in_port[i]  = 3'(p);
    in_defl[i]  = 3'(d);
    in_hops[i]  = 3'(h);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_idle();
    clear_in(); settle();
    chk("R1 idle grant", grant, 0);
    chk("R1 idle fail", fail, 0);
    chk("R9 idle set all", idle_set, 5'h1F);
    chk("R3 idle contend", contend, 0);
  endtask

  task automatic t_all_distinct();
    clear_in();
    for (int i = 0; i < 5; i++) put(i, 4 - i, i, i);
    settle();
    chk("R2 distinct all granted incl local", grant, 5'h1F);
    chk("R9 all ports busy", idle_set, 0);
    chk("R7 port of input 4 (local)", out_port[4], 0);
    chk("R8 hops bumped input 3", out_hops[3], 4);
  endtask

  task automatic t_defl_first();
    clear_in();
    put(0, 2, 2, 0);
    put(1, 2, 1, 7);
    settle();
    chk("R4 more deflections wins", grant, 5'b00001);
    chk("R1 loser fails", fail, 5'b00010);
    chk("R3 contend on port 2", contend, 5'b00100);
    chk("R7 loser gets no port", out_port[1], 7);
    chk("R8 loser hops unchanged", out_hops[1], 7);
    chk("R9 only port 2 busy", idle_set, 5'b11011);
  endtask

  task automatic t_hops_second();
    clear_in();
    put(2, 1, 3, 5);
    put(3, 1, 3, 4);
    put(4, 0, 0, 0);
    settle();
    chk("R5 more hops wins on equal deflections", grant, 5'b10100);
    chk("R2 lone local granted beside contention", grant[4], 1);
    chk("R3 contend port 1 only", contend, 5'b00010);
  endtask

  task automatic t_three_way();
    clear_in();
    put(0, 3, 1, 2);
    put(1, 3, 1, 6);
    put(4, 3, 0, 7);
    settle();
    chk("R5 three-way winner", grant, 5'b00010);
    chk("R4 three-way losers", fail, 5'b10001);
  endtask

  task automatic t_tie();
    int w1 = 0;
    int w2 = 0;
    clear_in();
    put(1, 3, 2, 2);
    put(2, 3, 2, 2);
    for (int c = 0; c < 40; c++) begin
      settle();
      chk("R6 exactly one tie winner", $countones(grant), 1);
      if (grant[1]) w1++;
      if (grant[2]) w2++;
    end
    chk("R6 input 1 wins some ties", (w1 > 0) ? 1 : 0, 1);
    chk("R6 input 2 wins some ties", (w2 > 0) ? 1 : 0, 1);
  endtask

  task automatic t_saturate();
    clear_in();
    put(0, 1, 0, 7);
    put(1, 2, 0, 6);
    settle();
    chk("R8 hop count held at 7", out_hops[0], 7);
    chk("R8 hop count 6 becomes 7", out_hops[1], 7);
  endtask

  task automatic t_bad_code();
    clear_in();
    put(0, 6, 7, 7);
    settle();
    chk("R9 code 6 not granted", grant, 0);
    chk("R1 code 6 fails", fail, 5'b00001);
    chk("R9 code 6 marks nothing busy", idle_set, 5'h1F);
    chk("R7 code 6 out port none", out_port[0], 7);
  endtask

  task automatic t_dead_input();
    clear_in();
    put(3, 4, 0, 0);
    in_port[0] = 3'd4; in_defl[0] = 3'd7; in_hops[0] = 3'd7;
    settle();
    chk("R3 invalid input not counted", contend, 0);
    chk("R2 valid input keeps port over dead one", grant, 5'b01000);
    chk("R1 dead input neither flag", fail, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_idle();
    t_all_distinct();
    t_defl_first();
    t_hops_second();
    t_three_way();
    t_tie();
    t_saturate();
    t_bad_code();
    t_dead_input();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule